// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits between a direct-mapped cache and the path that refills it from the next memory level. Lines that the cache throws out are parked here. Two lines that share a cache index can then trade places cheaply, and the repeated conflict miss does not cost a memory fetch.

The cache consults the buffer only when its own lookup misses. It presents the block address on the lookup port. One cycle later it receives hit or miss, and on a hit it also receives the line data and its dirty flag. The line the cache displaces to make room is presented on the eviction port in the same cycle. On a hit the displaced line takes the entry that was just handed back, which makes a swap. A hit with no eviction simply frees the entry, because the line now lives in the cache.

When an eviction arrives, does not match the lookup, and every entry is occupied, the entry that was filled longest ago is pushed out. A dirty line that is pushed out appears on the writeback port for one cycle. A clean one is dropped.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty: every lookup misses, and neither `rsp_valid` nor `wb_valid` is high until a request or an eviction causes it.
- R2: An evicted line may occupy any entry. Up to ENTRIES distinct lines are held at once, and each one later hits and returns the data and dirty flag it was stored with.
- R3: `rsp_valid` is high in exactly the cycle after `lk_valid` was high. `rsp_hit`, `rsp_data` and `rsp_dirty` reflect the buffer contents before any eviction accepted in the request cycle, so a line evicted in that same cycle is not visible to the lookup.
- R4: A lookup that hits while an eviction is presented is a swap. The evicted line takes the hit entry, no writeback occurs, the returned address then misses and the evicted address hits.
- R5: A lookup that hits with no eviction presented removes that line from the buffer. A lookup that misses leaves the contents unchanged.
- R6: An eviction that matches no held line, does not coincide with a lookup hit, and finds every entry valid replaces the line inserted least recently. Swaps and in-place updates count as insertions.
- R7: A replaced line that is dirty appears on `wb_addr`/`wb_data`, with `wb_valid` high for one cycle, in the cycle after the eviction. A replaced clean line produces no writeback.
- R8: At most one valid copy of any block address ever exists. An eviction whose address is already held overwrites that entry. Its dirty flag becomes the OR of the old and new flags, or only the new flag when a lookup returns that same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Eviction from the cache is presented |
| ev_addr | input | ADDR_W | Block address of the evicted line |
| ev_data | input | DATA_W | Evicted line data |
| ev_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | Lookup request after a cache miss |
| lk_addr | input | ADDR_W | Block address looked up |
| rsp_valid | output | 1 | Lookup response, one cycle after the request |
| rsp_hit | output | 1 | The looked-up line was found |
| rsp_data | output | DATA_W | Returned line data, valid when `rsp_hit` is high |
| rsp_dirty | output | 1 | Returned line is modified |
| wb_valid | output | 1 | A dirty line was pushed out |
| wb_addr | output | ADDR_W | Block address of the pushed-out line |
| wb_data | output | DATA_W | Data of the pushed-out line |

## Verification
The assertions check several properties on every cycle. No two valid entries ever share an address. The response follows the request by exactly one cycle. A hit never coincides with a writeback. A writeback only follows an eviction into a full buffer. A hit without an eviction frees exactly one entry. Which entry is the oldest, what data comes back, and how the dirty flags merge on in-place updates can only be shown through the bench's scenarios. The bench compares every output on every cycle against a queue model ordered by insertion, through directed sequences and a long random run over a narrow address range.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Where an incoming eviction is placed in the buffer
    typedef enum logic [2:0] {
        PL_NONE    = 3'd0,  // no eviction this cycle
        PL_UPDATE  = 3'd1,  // address already held: overwrite in place
        PL_SWAP    = 3'd2,  // take the entry just returned by a lookup hit
        PL_FREE    = 3'd3,  // lowest empty entry
        PL_REPLACE = 3'd4   // buffer full: displace the oldest insertion
    } place_e;

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);

    logic [ENTRIES-1:0] match_vec;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match_vec[gi] = valid[gi] && (tags[gi] == key);
    end

    assign hit = |match_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vb_age.sv
module vb_age #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [ENTRIES-1:0]  valid,
    output logic [IDX_W-1:0]    oldest_idx,
    output logic [IDX_W-1:0]    free_idx
);

    // older_q[i][j] set: entry i was inserted before entry j
    logic [ENTRIES-1:0][ENTRIES-1:0] older_d, older_q;
    logic [ENTRIES-1:0]              is_old;

    always_comb begin
        older_d = older_q;
        if (upd) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (IDX_W'(j) != upd_idx) begin
                    older_d[upd_idx][j] = 1'b0;
                    older_d[j][upd_idx] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    older_q[i][j] <= (i < j);
                end
            end
        end else begin
            older_q <= older_d;
        end
    end

    always_comb begin
        is_old = valid;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && valid[j] && !older_q[i][j]) is_old[i] = 1'b0;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (is_old[i]) oldest_idx = IDX_W'(i);
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_dirty,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             dirty;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic                           rsp_dirty;
        logic [DATA_W-1:0]              rsp_data;
        logic                           wb_valid;
        logic [ADDR_W-1:0]              wb_addr;
        logic [DATA_W-1:0]              wb_data;
    } state_t;

    state_t st_d, st_q;

    logic             lk_hit, ev_hit, lk_take, full, age_upd;
    logic [IDX_W-1:0] lk_idx, ev_idx, oldest_idx, free_idx, tgt_idx;
    place_e           place;

    // signals observed by the bound checker
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    assign ent_valid = st_q.valid;
    assign ent_addr  = st_q.addr;

    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
        .valid (st_q.valid),
        .tags  (st_q.addr),
        .key   (lk_addr),
        .hit   (lk_hit),
        .idx   (lk_idx)
    );

    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ev_match (
        .valid (st_q.valid),
        .tags  (st_q.addr),
        .key   (ev_addr),
        .hit   (ev_hit),
        .idx   (ev_idx)
    );

    vb_age #(.ENTRIES(ENTRIES)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (age_upd),
        .upd_idx    (tgt_idx),
        .valid      (st_q.valid),
        .oldest_idx (oldest_idx),
        .free_idx   (free_idx)
    );

    assign lk_take = lk_valid && lk_hit;
    assign full    = &st_q.valid;
    assign age_upd = (place != PL_NONE);

    // placement decision for the eviction
    always_comb begin
        if (!ev_valid)    place = PL_NONE;
        else if (ev_hit)  place = PL_UPDATE;
        else if (lk_take) place = PL_SWAP;
        else if (!full)   place = PL_FREE;
        else              place = PL_REPLACE;
    end

    always_comb begin
        unique case (place)
            PL_UPDATE:  tgt_idx = ev_idx;
            PL_SWAP:    tgt_idx = lk_idx;
            PL_FREE:    tgt_idx = free_idx;
            PL_REPLACE: tgt_idx = oldest_idx;
            default:    tgt_idx = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;

        // lookup response, from contents before this cycle's update
        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = lk_take;
        st_d.rsp_data  = lk_take ? st_q.data[lk_idx] : '0;
        st_d.rsp_dirty = lk_take && st_q.dirty[lk_idx];

        st_d.wb_valid  = 1'b0;

        // a hit hands the line to the cache
        if (lk_take) st_d.valid[lk_idx] = 1'b0;

        if (place == PL_REPLACE && st_q.dirty[tgt_idx]) begin
            st_d.wb_valid = 1'b1;
            st_d.wb_addr  = st_q.addr[tgt_idx];
            st_d.wb_data  = st_q.data[tgt_idx];
        end

        if (place != PL_NONE) begin
            st_d.valid[tgt_idx] = 1'b1;
            st_d.addr[tgt_idx]  = ev_addr;
            st_d.data[tgt_idx]  = ev_data;
            if (place == PL_UPDATE && !(lk_take && lk_idx == ev_idx)) begin
                st_d.dirty[tgt_idx] = st_q.dirty[tgt_idx] | ev_dirty;
            end else begin
                st_d.dirty[tgt_idx] = ev_dirty;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_dirty = st_q.rsp_dirty;
    assign wb_valid  = st_q.wb_valid;
    assign wb_addr   = st_q.wb_addr;
    assign wb_data   = st_q.wb_data;

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           lk_valid,
    input logic                           ev_valid,
    input logic                           rsp_valid,
    input logic                           rsp_hit,
    input logic                           wb_valid,
    input logic [ENTRIES-1:0]             valid_q,
    input logic [ENTRIES-1:0][ADDR_W-1:0] addr_q
);

    // R1: reset empties the buffer
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R3: response exactly one cycle after a request
    a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R4: a hit never pushes a line out
    a_r4_hit_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !wb_valid);

    // R5: a hit without an eviction frees exactly one entry
    a_r5_hit_frees_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !$past(ev_valid)) |->
            ($countones(valid_q) + 1 == $past($countones(valid_q))));

    // R7: writeback only after an eviction into a full buffer
    a_r7_wb_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(&valid_q) && $past(ev_valid)));

    // R8: never two valid copies of one address
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_pi
        for (genvar gj = gi + 1; gj < ENTRIES; gj++) begin : g_pj
            a_r8_unique_lines: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_q[gi] && valid_q[gj]) |-> (addr_q[gi] != addr_q[gj]));
        end
    end

endmodule

bind victim_buffer vb_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .ev_valid  (ev_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .wb_valid  (wb_valid),
    .valid_q   (ent_valid),
    .addr_q    (ent_addr)
);

// File: tb/sim_victim_buffer.sv
module sim_victim_buffer;

    localparam int E = 4;
    localparam int A = 26;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_valid = 1'b0;
    logic [A-1:0] ev_addr = '0;
    logic [D-1:0] ev_data = '0;
    logic         ev_dirty = 1'b0;
    logic         lk_valid = 1'b0;
    logic [A-1:0] lk_addr = '0;
    logic         rsp_valid, rsp_hit, rsp_dirty, wb_valid;
    logic [D-1:0] rsp_data, wb_data;
    logic [A-1:0] wb_addr;

    always #2 clk = ~clk;

    victim_buffer #(.ENTRIES(E), .ADDR_W(A), .DATA_W(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data), .ev_dirty(ev_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // reference model: queue ordered by insertion, front is oldest
    typedef struct {
        logic [A-1:0] a;
        logic [D-1:0] d;
        logic         dy;
    } line_t;
    line_t q[$];

    logic         exp_rv = 1'b0, exp_hit = 1'b0, exp_rdy = 1'b0, exp_wb = 1'b0;
    logic [D-1:0] exp_rd = '0, exp_wbd = '0;
    logic [A-1:0] exp_wba = '0;
    int    checks = 0, errors = 0, seq = 0;
    string req = "R1";
    bit    done = 1'b0;

    task automatic chk(string r, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL [%s] %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk(req, "rsp_valid", rsp_valid, exp_rv);
        chk(req, "rsp_hit", rsp_hit, exp_hit);
        if (exp_hit) begin
            chk(req, "rsp_data", rsp_data, exp_rd);
            chk(req, "rsp_dirty", rsp_dirty, exp_rdy);
        end
        chk(req, "wb_valid", wb_valid, exp_wb);
        if (exp_wb) begin
            chk(req, "wb_addr", wb_addr, exp_wba);
            chk(req, "wb_data", wb_data, exp_wbd);
        end
    endtask

    function automatic int find(logic [A-1:0] a);
        foreach (q[i]) if (q[i].a == a) return i;
        return -1;
    endfunction

    task automatic remove_addr(logic [A-1:0] a);
        int k;
        k = find(a);
        if (k >= 0) q.delete(k);
    endtask

    task automatic step(bit lv, logic [A-1:0] la, bit ev, logic [A-1:0] ea, bit edy);
        int h, m;
        line_t n;
        logic [D-1:0] ed;
        @(negedge clk);
        compare_outputs();
        seq++;
        ed = {32'(ea), 32'(seq)};
        lk_valid = lv; lk_addr = la;
        ev_valid = ev; ev_addr = ea; ev_data = ed; ev_dirty = edy;
        h = lv ? find(la) : -1;
        exp_rv  = lv;
        exp_hit = (h >= 0);
        if (h >= 0) begin
            exp_rd  = q[h].d;
            exp_rdy = q[h].dy;
        end
        exp_wb = 1'b0;
        if (ev) begin
            m = find(ea);
            n.a = ea; n.d = ed; n.dy = edy;
            if (m >= 0 && !(h >= 0 && q[h].a == ea)) n.dy = edy | q[m].dy;
            if (h >= 0) remove_addr(la);
            if (m >= 0) remove_addr(ea);
            if (m < 0 && h < 0 && q.size() == E) begin
                exp_wb  = q[0].dy;
                exp_wba = q[0].a;
                exp_wbd = q[0].d;
                void'(q.pop_front());
            end
            q.push_back(n);
        end else if (h >= 0) begin
            remove_addr(la);
        end
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL [watchdog] run did not complete: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        req = "R1";
        step(1, 26'd5, 0, '0, 0);
        idle();

        // R2: fill every entry, each returns its own line (lookups also free, R5)
        req = "R2";
        step(0, '0, 1, 26'd1, 1);
        step(0, '0, 1, 26'd2, 0);
        step(0, '0, 1, 26'd3, 1);
        step(0, '0, 1, 26'd4, 0);
        for (int i = 1; i <= 4; i++) step(1, A'(i), 0, '0, 0);
        idle();

        // R5: freed line now misses; a miss changes nothing
        req = "R5";
        step(0, '0, 1, 26'd7, 1);
        step(1, 26'd1, 0, '0, 0);
        step(1, 26'd8, 0, '0, 0);
        step(1, 26'd7, 0, '0, 0);
        step(1, 26'd7, 0, '0, 0);
        idle();

        // R4: swap
        req = "R4";
        step(0, '0, 1, 26'd3, 1);
        step(1, 26'd3, 1, 26'd9, 0);
        step(1, 26'd3, 0, '0, 0);
        step(1, 26'd9, 0, '0, 0);
        idle();

        // R6 and R7: oldest replaced, dirty ones written back, clean dropped
        req = "R6";
        step(0, '0, 1, 26'd10, 1);
        step(0, '0, 1, 26'd11, 0);
        step(0, '0, 1, 26'd12, 1);
        step(0, '0, 1, 26'd13, 1);
        step(0, '0, 1, 26'd14, 0);
        req = "R7";
        step(0, '0, 1, 26'd15, 0);
        step(0, '0, 1, 26'd16, 0);
        idle();

        // R8: eviction of an address already held
        req = "R8";
        step(0, '0, 1, 26'd14, 1);
        step(0, '0, 1, 26'd14, 0);
        step(1, 26'd15, 1, 26'd15, 0);
        step(1, 26'd14, 0, '0, 0);
        step(1, 26'd15, 0, '0, 0);
        idle();

        // R3: same-cycle lookup and insert of an absent address
        req = "R3";
        step(1, 26'd20, 1, 26'd20, 1);
        step(1, 26'd20, 0, '0, 0);
        idle();

        // mixed random traffic over a narrow address range
        req = "R6";
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 1) == 1, A'($urandom_range(0, 9)),
                 $urandom_range(0, 3) != 0, A'($urandom_range(0, 9)),
                 $urandom_range(0, 1) == 1);
        end
        idle();
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule